// File: doc/BRIEF.md
# Register-Buffered Data Stack

This block is the operand stack of an 18-bit stack processor. The two values an instruction works on most often, the top entry and the one beneath it, are each held in their own flip-flops. Every deeper entry lives in a small circular array. Each cycle the block takes a 2-bit stack-adjust code and a candidate top value from the instruction datapath. It then updates its pointer, spills to the array or refills from it, and shows the new top and second values as plain register outputs.

Both outputs come straight from flip-flops, so nothing between the pointer, the array and the outputs is combinational. That lets a memory port take its address or write data from the stack in the cycle right after an instruction that moved the pointer. No settling slot is needed. The array has a synchronous write and is small enough to map onto distributed RAM. The pointer simply wraps: nothing detects or traps a stack that grows past its depth.

Top module: `dstack`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tos`, `nos` and the internal pointer become 0. After release, pushing values a then b and then dropping two (code 11) gives `tos`=0 and `nos`=0.
- R2: Code 00 (hold) loads `tos_in` into `tos` and leaves `nos` and the pointer unchanged.
- R3: Code 01 (push) stores the old `nos` in the array, moves the old `tos` to `nos`, loads `tos_in` into `tos` and advances the pointer by one.
- R4: Code 10 (drop one) loads `tos_in` into `tos`, refills `nos` from the most recently spilled array entry and moves the pointer back by one.
- R5: Code 11 (drop two) ignores `tos_in`. It loads `tos` from the most recently spilled entry, loads `nos` from the entry beneath it, and moves the pointer back by two.
- R6: `tos` and `nos` change only at a rising clock edge. Input changes within a cycle do not reach them before that edge.
- R7: The array has 16 entries and the pointer wraps modulo 16 with no overflow detection. After 20 pushes of v1..v20, the first 16 drop-one refills of `nos` give v18 down to v3, and the 17th gives v18 again.
- R8: A push followed at once by a drop one restores `nos` to the value it had before the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sp_delta | input | 2 | Stack-adjust code: 00 hold, 01 push, 10 drop one, 11 drop two |
| tos_in | input | 18 | New top-of-stack value from the datapath |
| tos | output | 18 | Registered top of stack |
| nos | output | 18 | Registered second stack entry |

## Verification
Drop one does two things in the same cycle: it loads a fresh top value from `tos_in` and refills the second value from the array at the pointer it is just leaving. Push likewise writes the array while both registers shift. The bench provokes this overlap with back-to-back push/drop-one pairs that use distinct values, and with a drop one right after a run of pushes. One cycle later it compares both outputs against a reference stack, so a refill read from the wrong slot or a top value taken from the wrong source shows up as a miscompare. Inputs are also changed in the middle of a cycle to show that neither output moves before the edge.

// File: rtl/ds_pkg.sv
package ds_pkg;

  // Stack-adjust code carried in the instruction word.
  typedef enum logic [1:0] {
    DS_HOLD  = 2'b00,
    DS_PUSH  = 2'b01,
    DS_DROP1 = 2'b10,
    DS_DROP2 = 2'b11
  } ds_op_e;

endpackage

// File: rtl/ds_ptr.sv
module ds_ptr
  import ds_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ds_op_e           op,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_m1,
  output logic [PTR_W-1:0] sp_p1
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  logic [PTR_W-1:0] sp_next;

  always_comb begin
    sp_p1 = sp + ONE;
    sp_m1 = sp - ONE;
    unique case (op)
      DS_PUSH:  sp_next = sp_p1;
      DS_DROP1: sp_next = sp_m1;
      DS_DROP2: sp_next = sp - TWO;
      default:  sp_next = sp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else     sp <= sp_next;
  end

endmodule

// File: rtl/ds_ram.sv
module ds_ram #(
  parameter int WIDTH  = 18,
  parameter int DEPTH  = 16,
  parameter int N_RD   = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [WIDTH-1:0]            wdata,
  input  logic [N_RD-1:0][ADDR_W-1:0] raddr,
  output logic [N_RD-1:0][WIDTH-1:0]  rdata
);

  // Synchronous write, asynchronous read: distributed-RAM shape.
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/ds_regs.sv
module ds_regs
  import ds_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  ds_op_e           op,
  input  logic [WIDTH-1:0] tos_in,
  input  logic [WIDTH-1:0] fill_hi,   // entry at the pointer
  input  logic [WIDTH-1:0] fill_lo,   // entry one below the pointer
  output logic [WIDTH-1:0] tos_q,
  output logic [WIDTH-1:0] nos_q
);

  logic [WIDTH-1:0] tos_d, nos_d;

  always_comb begin
    tos_d = tos_in;
    nos_d = nos_q;
    unique case (op)
      DS_PUSH:  nos_d = tos_q;
      DS_DROP1: nos_d = fill_hi;
      DS_DROP2: begin
        tos_d = fill_hi;
        nos_d = fill_lo;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      nos_q <= '0;
    end else begin
      tos_q <= tos_d;
      nos_q <= nos_d;
    end
  end

endmodule

// File: rtl/dstack.sv
module dstack
  import ds_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sp_delta,
  input  logic [WIDTH-1:0] tos_in,
  output logic [WIDTH-1:0] tos,
  output logic [WIDTH-1:0] nos
);

  ds_op_e                   op;
  logic [ADDR_W-1:0]        sp_q, sp_m1, sp_p1;
  logic [1:0][ADDR_W-1:0]   rd_addr;
  logic [1:0][WIDTH-1:0]    rd_data;

  assign op = ds_op_e'(sp_delta);

  ds_ptr #(.PTR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .sp    (sp_q),
    .sp_m1 (sp_m1),
    .sp_p1 (sp_p1)
  );

  assign rd_addr[0] = sp_q;
  assign rd_addr[1] = sp_m1;

  // Spill of the old second entry goes to the slot above the pointer.
  ds_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .N_RD(2)) u_ram (
    .clk   (clk),
    .we    (op == DS_PUSH),
    .waddr (sp_p1),
    .wdata (nos),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  ds_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .tos_in  (tos_in),
    .fill_hi (rd_data[0]),
    .fill_lo (rd_data[1]),
    .tos_q   (tos),
    .nos_q   (nos)
  );

endmodule

// File: rtl/ds_check.sv
module ds_check #(
  parameter int WIDTH = 18,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       sp_delta,
  input logic [WIDTH-1:0] tos_in,
  input logic [WIDTH-1:0] tos,
  input logic [WIDTH-1:0] nos,
  input logic [PTR_W-1:0] sp
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state observed after a reset edge is all zero
  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_zero_r1: assert (tos == '0 && nos == '0 && sp == '0)
        else $error("reset state not zero");
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    sp_delta == 2'b00 |=> tos == $past(tos_in) && $stable(nos) && $stable(sp));

  p_push_r3: assert property (@(posedge clk) disable iff (rst)
    sp_delta == 2'b01 |=> tos == $past(tos_in) && nos == $past(tos)
                          && sp == $past(sp) + ONE);

  p_drop1_r4: assert property (@(posedge clk) disable iff (rst)
    sp_delta == 2'b10 |=> tos == $past(tos_in) && sp == $past(sp) - ONE);

  p_drop2_r5: assert property (@(posedge clk) disable iff (rst)
    sp_delta == 2'b11 |=> sp == $past(sp) - TWO);

  p_restore_r8: assert property (@(posedge clk) disable iff (rst)
    (sp_delta == 2'b01 ##1 sp_delta == 2'b10) |=> nos == $past(nos, 2));

endmodule

bind dstack ds_check #(.WIDTH(WIDTH), .PTR_W(ADDR_W)) u_ds_check (
  .clk      (clk),
  .rst      (rst),
  .sp_delta (sp_delta),
  .tos_in   (tos_in),
  .tos      (tos),
  .nos      (nos),
  .sp       (sp_q)
);

// File: tb/test_dstack.sv
module test_dstack;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   sp_delta = 2'b00;
  logic [W-1:0] tos_in = '0;
  logic [W-1:0] tos, nos;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference stack, per R1..R7
  logic [W-1:0] m_tos, m_nos;
  logic [W-1:0] m_arr [16];
  logic [3:0]   m_sp;

  always #4 clk = ~clk;

  dstack i_dstack (
    .clk(clk), .rst(rst), .sp_delta(sp_delta),
    .tos_in(tos_in), .tos(tos), .nos(nos)
  );

  task automatic chk(input string req, input logic [W-1:0] et, input logic [W-1:0] en);
    n_vec++;
    if (tos !== et || nos !== en) begin
      n_bad++;
      $display("FAIL %s: tos=%h nos=%h expected tos=%h nos=%h", req, tos, nos, et, en);
    end
  endtask

  task automatic model(input logic [1:0] op, input logic [W-1:0] v);
    case (op)
      2'b00: m_tos = v;
      2'b01: begin m_sp = m_sp + 4'd1; m_arr[m_sp] = m_nos; m_nos = m_tos; m_tos = v; end
      2'b10: begin m_tos = v; m_nos = m_arr[m_sp]; m_sp = m_sp - 4'd1; end
      default: begin m_tos = m_arr[m_sp]; m_nos = m_arr[m_sp - 4'd1]; m_sp = m_sp - 4'd2; end
    endcase
  endtask

  // drive at negedge, result visible after the next rising edge
  task automatic step(input logic [1:0] op, input logic [W-1:0] v);
    @(negedge clk);
    sp_delta = op;
    tos_in   = v;
    @(posedge clk);
    model(op, v);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sp_delta = 2'b00; tos_in = '0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    m_tos = '0; m_nos = '0; m_sp = '0;
    for (int i = 0; i < 16; i++) m_arr[i] = '0;
  endtask

  task automatic t_reset();
    step(2'b01, 18'h1111); step(2'b01, 18'h2222);
    do_reset();
    chk("R1 reset", '0, '0);
    step(2'b01, 18'h0A0A); step(2'b01, 18'h0B0B);
    step(2'b11, 18'h3FFFF);
    chk("R1 pointer from zero", '0, '0);
    do_reset();
  endtask

  task automatic t_hold();
    step(2'b01, 18'h00101); step(2'b01, 18'h00202);
    step(2'b00, 18'h00303);
    chk("R2 hold", 18'h00303, 18'h00101);
    step(2'b10, 18'h00404);
    chk("R2 pointer kept", m_tos, m_nos);
  endtask

  task automatic t_push();
    step(2'b01, 18'h12345);
    chk("R3 push", 18'h12345, m_nos);
    step(2'b01, 18'h2ABCD);
    chk("R3 push shift", 18'h2ABCD, 18'h12345);
    step(2'b01, 18'h3F00F);
    chk("R3 push spill", m_tos, m_nos);
  endtask

  task automatic t_drop1();
    step(2'b10, 18'h01234);
    chk("R4 drop one", m_tos, m_nos);
    step(2'b10, 18'h05678);
    chk("R4 drop one again", 18'h05678, m_nos);
  endtask

  task automatic t_drop2();
    step(2'b01, 18'h0AAAA); step(2'b01, 18'h15555); step(2'b01, 18'h2F0F0);
    step(2'b11, 18'h3FFFF);   // tos_in must be ignored
    chk("R5 drop two", 18'h0AAAA, m_nos);
  endtask

  task automatic t_stable();
    logic [W-1:0] t0, n0;
    step(2'b01, 18'h01010);
    t0 = tos; n0 = nos;
    @(negedge clk);
    sp_delta = 2'b01; tos_in = 18'h22222;
    #1;
    sp_delta = 2'b11; tos_in = 18'h33333;
    #2;
    chk("R6 mid-cycle stable", t0, n0);
    sp_delta = 2'b00; tos_in = 18'h04444;
    @(posedge clk); model(2'b00, 18'h04444); #1;
    chk("R6 edge update", 18'h04444, n0);
  endtask

  task automatic t_restore();
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] n_before;
      n_before = nos;
      step(2'b01, W'(18'h100 + i));
      step(2'b10, W'(18'h200 + i));
      chk("R8 push/drop restore", W'(18'h200 + i), n_before);
    end
  endtask

  task automatic t_wrap();
    logic [W-1:0] first;
    do_reset();
    for (int k = 1; k <= 20; k++) step(2'b01, W'(k));
    first = '0;
    for (int d = 1; d <= 17; d++) begin
      step(2'b10, 18'h3C000);
      if (d == 1) first = nos;
      if (d <= 16) chk("R7 refill order", 18'h3C000, W'(19 - d));
      else         chk("R7 wrap repeat", 18'h3C000, first);
    end
  endtask

  initial begin
    do_reset();
    t_reset();
    t_push();
    t_hold();
    t_drop1();
    t_drop2();
    t_stable();
    t_restore();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule